// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog timer with a restart window. A 12-bit counter counts down by one on each pulse of a slow tick enable (256 Hz in the intended system, so a full reload of 0xFFF spans 16 seconds). Software must restart the counter before it expires, and it must not restart too early. A restart that arrives while the counter is still above the window threshold is a fault, just like letting the counter run out.

Software sets the block up once through a mode register, which locks after its first write. Restarts go through a key-protected control register. Two sticky status bits report which kind of fault happened, and reading them clears them. A fault can raise a level interrupt and can send a one-cycle reset pulse to either the processor-only reset output or the full system reset output. A disable bit stops the block completely. Two halt bits freeze the count while the idle input or the debug input is high.

Register map (word index on `reg_addr`): 0 control, 1 mode, 2 status, 3 current count (read only).

Top module: `win_wdog`

## Requirements
- R1: After reset, the mode register reads 0x3FFF2FFF, the count reads 0xFFF, the status reads 0 and all three fault outputs are low.
- R2: Only the first mode write after reset is stored, masked to bits [29:0], and that write also loads the count from bits [11:0]. Any later mode write leaves both the mode register and the count as they were.
- R3: When the count is not frozen, each slow tick lowers it by one. A tick that arrives while the count is 0 is an underflow fault and reloads the count from mode bits [11:0].
- R4: A control write with 0xA5 in bits [31:24] and bit 0 set reloads the count from mode bits [11:0]. A control write with any other key, or with bit 0 clear, has no effect.
- R5: An accepted restart while the count is greater than the window value in mode bits [27:16] is an early-restart fault. A restart while the count is at or below the window value is not a fault.
- R6: Status bit 0 records an underflow and status bit 1 records an early restart. Both bits are sticky and clear when the status register is read. A fault in the same cycle as the read wins over the clear.
- R7: `fault_irq` is high exactly when mode bit 12 is set and at least one status bit is set.
- R8: When mode bit 13 is set, each fault produces a one-cycle pulse in the cycle after it. The pulse goes on `proc_rst` if mode bit 14 is set, and on `sys_rst` if it is clear. When mode bit 13 is clear, neither output pulses.
- R9: While mode bit 15 is set, the count holds its value, restarts are ignored, and no fault, status bit or reset is produced.
- R10: Mode bit 28 freezes the count while `dbg_in` is high, and mode bit 29 freezes it while `idle_in` is high. An input whose halt bit is clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Single-cycle count enable (256 Hz rate) |
| idle_in | input | 1 | Processor idle indication |
| dbg_in | input | 1 | Debugger halt indication |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status when reading address 2) |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| fault_irq | output | 1 | Fault interrupt (level) |
| proc_rst | output | 1 | Processor-only reset pulse |
| sys_rst | output | 1 | Full system reset pulse |

## Verification
The bench uses the default key (0xA5). For the sweep it writes small reload and window values, 0 to 6 each, into the mode register, resetting the block before every pair. With values this small, every restart point from a full count down to zero can be reached in a few cycles, so each side of the window comparison is tested, including equality. Interrupt enable, reset enable and reset scope change with the pair, so all of the output routing is covered too. One run with the reset-default mode lets the full 4096-tick span run out to a system reset.

// File: rtl/win_wdog.sv
module win_wdog #(
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        idle_in,
  input  logic        dbg_in,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        fault_irq,
  output logic        proc_rst,
  output logic        sys_rst
);
  localparam int CW = 12;
  localparam logic [31:0] MODE_RST  = 32'h3FFF_2FFF;
  localparam logic [31:0] MODE_MASK = 32'h3FFF_FFFF;
  localparam logic [1:0] A_CTRL = 2'd0, A_MODE = 2'd1, A_STAT = 2'd2, A_CNT = 2'd3;

  logic [31:0]   mode_q;
  logic          locked_q;
  logic [CW-1:0] cnt_q;
  logic          st_unf, st_err;

  wire [CW-1:0] reload  = mode_q[CW-1:0];
  wire [CW-1:0] window  = mode_q[16 +: CW];
  wire          irq_en  = mode_q[12];
  wire          rst_en  = mode_q[13];
  wire          prc_sel = mode_q[14];
  wire          off     = mode_q[15];
  wire          dbg_hlt = mode_q[28];
  wire          idl_hlt = mode_q[29];

  wire mode_wr  = reg_wr && reg_addr == A_MODE && !locked_q;
  wire key_ok   = reg_wr && reg_addr == A_CTRL && reg_wdata[31:24] == KEY && reg_wdata[0];
  wire restart  = key_ok && !off;
  wire frozen   = off || (dbg_hlt && dbg_in) || (idl_hlt && idle_in);
  wire step     = slow_tick && !frozen;
  wire early    = restart && cnt_q > window;
  wire underrun = step && !restart && !mode_wr && cnt_q == '0;
  wire fault    = early || underrun;
  wire st_clr   = reg_rd && reg_addr == A_STAT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_RST;
      locked_q <= 1'b0;
    end else if (mode_wr) begin
      mode_q   <= reg_wdata & MODE_MASK;
      locked_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= MODE_RST[CW-1:0];
    else if (mode_wr)             cnt_q <= reg_wdata[CW-1:0];
    else if (restart || underrun) cnt_q <= reload;
    else if (step)                cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_unf   <= 1'b0;
      st_err   <= 1'b0;
      proc_rst <= 1'b0;
      sys_rst  <= 1'b0;
    end else begin
      st_unf   <= (st_unf && !st_clr) || underrun;
      st_err   <= (st_err && !st_clr) || early;
      proc_rst <= fault && rst_en && prc_sel;
      sys_rst  <= fault && rst_en && !prc_sel;
    end
  end

  assign fault_irq = irq_en && (st_unf || st_err);

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = mode_q;
      A_STAT:  reg_rdata = {30'd0, st_err, st_unf};
      A_CNT:   reg_rdata = {{(32-CW){1'b0}}, cnt_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

module win_wdog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        slow_tick,
  input logic        idle_in,
  input logic        dbg_in,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic        fault_irq,
  input logic        proc_rst,
  input logic        sys_rst,
  input logic [31:0] mode_q,
  input logic        locked_q,
  input logic [11:0] cnt_q
);
  wire halted = mode_q[15] || (mode_q[28] && dbg_in) || (mode_q[29] && idle_in);

  a_r2_locked_mode: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q && reg_wr && reg_addr == 2'd1 |=> $stable(mode_q));

  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick && !halted && cnt_q != 12'd0 && !reg_wr |=> cnt_q == $past(cnt_q) - 12'd1);

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> mode_q[12]);

  a_r8_proc_scope: assert property (@(posedge clk) disable iff (!rst_n)
    proc_rst |-> $past(mode_q[13]) && $past(mode_q[14]));

  a_r8_sys_scope: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> $past(mode_q[13]) && !$past(mode_q[14]));

  a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[15] && $past(mode_q[15]) |-> !proc_rst && !sys_rst);

  a_r9_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[15] && !(reg_wr && reg_addr == 2'd1) |=> $stable(cnt_q));
endmodule

bind win_wdog win_wdog_chk u_chk (.*);

// File: tb/test_win_wdog.sv
module test_win_wdog;
  logic clk = 1'b0, rst_n = 1'b0;
  logic slow_tick = 0, idle_in = 0, dbg_in = 0, reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic fault_irq, proc_rst, sys_rst;
  int checks = 0, errors = 0;
  int n_sys = 0, n_proc = 0;

  always #4 clk = ~clk;

  win_wdog i_win_wdog (.*);

  always @(negedge clk) begin
    if (sys_rst)  n_sys  <= n_sys + 1;
    if (proc_rst) n_proc <= n_proc + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1;
      @(negedge clk); slow_tick = 0;
    end
  endtask

  task automatic run_all();
    logic [31:0] r;
    int s0, p0;
    // R1 reset state and default expiry to system reset
    do_reset();
    rd(2'd1, r); check("R1 mode", r, 32'h3FFF2FFF);
    rd(2'd3, r); check("R1 count", r, 32'hFFF);
    rd(2'd2, r); check("R1 status", r, 0);
    check("R1 outputs", {fault_irq, proc_rst, sys_rst}, 0);
    s0 = n_sys; p0 = n_proc;
    tick(4095);
    rd(2'd3, r); check("R3 default reaches zero", r, 0);
    check("R8 no early pulse", n_sys - s0, 0);
    tick(1);
    @(negedge clk);
    check("R8 default sys pulse", n_sys - s0, 1);
    check("R8 default no proc", n_proc - p0, 0);
    rd(2'd2, r); check("R6 underflow bit", r, 1);
    rd(2'd3, r); check("R3 reload after underflow", r, 32'hFFF);

    // sweep of reload and window values
    for (int v = 0; v <= 6; v++) begin
      for (int d = 0; d <= 6; d++) begin
        logic fie, ren, prc;
        int es, ep;
        fie = d[0]; ren = (v != 3); prc = v[1];
        do_reset();
        s0 = n_sys; p0 = n_proc; es = 0; ep = 0;
        wr(2'd1, 32'(v) | (32'(fie) << 12) | (32'(ren) << 13) | (32'(prc) << 14) | (32'(d) << 16));
        rd(2'd3, r); check("R2 mode write loads count", r, 32'(v));
        for (int j = 0; j <= v; j++) begin
          logic e;
          tick(j);
          rd(2'd3, r); check("R3 decrement", r, 32'(v - j));
          e = (v - j) > d;
          wr(2'd0, 32'hA500_0001);
          if (e && ren) begin if (prc) ep++; else es++; end
          check("R7 irq after restart", fault_irq, fie & e);
          rd(2'd2, r); check("R5 early restart status", r, {30'd0, e, 1'b0});
          check("R6 irq cleared by read", fault_irq, 0);
          rd(2'd3, r); check("R4 restart reloads", r, 32'(v));
        end
        tick(v);
        rd(2'd2, r); check("R3 no fault before underflow", r, 0);
        tick(1);
        if (ren) begin if (prc) ep++; else es++; end
        check("R7 irq after underflow", fault_irq, fie);
        rd(2'd2, r); check("R6 underflow status", r, 1);
        rd(2'd3, r); check("R3 reload on underflow", r, 32'(v));
        check("R8 sys pulses", n_sys - s0, es);
        check("R8 proc pulses", n_proc - p0, ep);
      end
    end

    // R2 lock and R4 key checks
    do_reset();
    wr(2'd1, 32'h0005_0005);
    wr(2'd1, 32'h3FFF_FFFF);
    rd(2'd1, r); check("R2 second write ignored", r, 32'h0005_0005);
    rd(2'd3, r); check("R2 count kept", r, 5);
    tick(2);
    wr(2'd0, 32'h5A00_0001);
    rd(2'd3, r); check("R4 wrong key ignored", r, 3);
    wr(2'd0, 32'hA500_0000);
    rd(2'd3, r); check("R4 missing restart bit ignored", r, 3);
    wr(2'd0, 32'hA500_0001);
    rd(2'd3, r); check("R4 keyed restart", r, 5);
    rd(2'd2, r); check("R5 in-window restart no fault", r, 0);

    // R9 disable
    do_reset();
    s0 = n_sys; p0 = n_proc;
    wr(2'd1, 32'h0000_A005);
    tick(8);
    rd(2'd3, r); check("R9 count held", r, 5);
    wr(2'd0, 32'hA500_0001);
    rd(2'd2, r); check("R9 no status", r, 0);
    @(negedge clk);
    check("R9 no reset pulses", (n_sys - s0) + (n_proc - p0), 0);

    // R10 halt bits
    do_reset();
    wr(2'd1, 32'h1007_0005);
    dbg_in = 1; tick(3);
    rd(2'd3, r); check("R10 debug halt", r, 5);
    dbg_in = 0; idle_in = 1; tick(2);
    rd(2'd3, r); check("R10 idle without its bit", r, 3);
    idle_in = 0;
    do_reset();
    wr(2'd1, 32'h2007_0005);
    idle_in = 1; tick(3);
    rd(2'd3, r); check("R10 idle halt", r, 5);
    idle_in = 0; dbg_in = 1; tick(1);
    rd(2'd3, r); check("R10 debug without its bit", r, 4);
    dbg_in = 0;
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule